// File: doc/BRIEF.md
# Reset Vector Configuration Loader

This block runs the start-up sequence of a processor core. When reset is released it issues one read of a 32-bit word from the fixed address 0xFFFF_FFE0 on a single-word request/response memory port. From that one word it derives the starting program counter, which is aligned to 16 bytes. It also derives four configuration bits: the bus byte-order select, two row/column addressing mode bits and a lock bit. The status register is set to its initial value at the same moment. One cycle after the word arrives, the block sends the core a one-cycle start pulse.

The block also holds the 32-bit configuration register, which software writes through a simple write-enable port. Once the lock bit is 1, the low byte of the register (bits 7:0) is frozen. The upper 24 bits stay writable. Only a new reset clears the lock, and a new reset also repeats the whole fetch. The general-purpose register files and the instruction cache are not touched.

The sequencer has four states:
- `ST_HOLD` is entered during reset.
- `ST_HOLD -> ST_FETCH` happens on the first clock after reset is released.
- `ST_FETCH` drives the read request. `ST_FETCH -> ST_LAUNCH` happens on the cycle a response is valid.
- `ST_LAUNCH` drives the start pulse. `ST_LAUNCH -> ST_RUN` happens unconditionally.
- `ST_RUN` is held until the next reset.

Top module: `rvec_loader`

## Requirements
- R1: While reset is asserted, `pc_out`, `status_out` and `cfg_out` are 0, `busy` is 1, and both `start` and `mem_req` are 0.
- R2: From the first cycle after reset release until a response is accepted, `mem_req` is 1 and `mem_addr` is 0xFFFF_FFE0.
- R3: After the response, `pc_out` equals the response word with its bits 3:0 forced to 0.
- R4: After the response, `status_out` is 0x0000_0010.
- R5: After the response, `cfg_out` bit 0 (byte order), bits 2:1 (row/column mode) and bit 3 (lock) equal the same bits of the response word, and all other bits are 0.
- R6: `start` is 1 for exactly one cycle, the cycle after the response is accepted. `busy` is 1 up to and including the response cycle and 0 from the start cycle onward.
- R7: Configuration writes made while `busy` is 1 are ignored.
- R8: While `cfg_out[3]` is 0, a write replaces all 32 bits of `cfg_out` on the next cycle.
- R9: While `cfg_out[3]` is 1, a write leaves `cfg_out[7:0]` unchanged and still replaces `cfg_out[31:8]`.
- R10: A second reset clears the lock and repeats the fetch and load sequence.
- R11: A response that arrives while no fetch is pending has no effect on `pc_out`, `status_out` or `cfg_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_req | output | 1 | Read request for the start-up word |
| mem_addr | output | 32 | Read address, fixed at 0xFFFF_FFE0 |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response word |
| cfg_we | input | 1 | Configuration register write enable |
| cfg_wdata | input | 32 | Configuration register write data |
| pc_out | output | 32 | Start program counter |
| status_out | output | 32 | Status register |
| cfg_out | output | 32 | Configuration register |
| busy | output | 1 | High until the start pulse |
| start | output | 1 | One-cycle start pulse to the core |

## Verification
The hardest condition to reach is the lock taking hold partway through operation. Software must first set the lock bit with an unlocked write, and the very next write must then show a frozen low byte while the upper bits still change. The bench boots once with the lock clear and makes that pair of writes. It then resets again to show that the lock is gone and that the fetch repeats. Stray writes during the fetch wait, and a stray response after start-up, are also driven to show that neither disturbs the loaded state.

// File: rtl/rvl_pkg.sv
package rvl_pkg;
    typedef enum logic [1:0] {
        ST_HOLD   = 2'd0,
        ST_FETCH  = 2'd1,
        ST_LAUNCH = 2'd2,
        ST_RUN    = 2'd3
    } boot_state_t;

    // Bit positions inside the configuration word (also taken from the vector)
    localparam int unsigned BIT_ORDER  = 0;
    localparam int unsigned BIT_RC_LO  = 1;
    localparam int unsigned BIT_RC_HI  = 2;
    localparam int unsigned BIT_LOCK   = 3;
endpackage

// File: rtl/rvl_fsm.sv
module rvl_fsm
    import rvl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rsp_valid,
    output boot_state_t state,
    output logic        req,
    output logic        load,
    output logic        busy,
    output logic        start
);
    boot_state_t nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_HOLD:   nxt = ST_FETCH;
            ST_FETCH:  if (rsp_valid) nxt = ST_LAUNCH;
            ST_LAUNCH: nxt = ST_RUN;
            ST_RUN:    nxt = ST_RUN;
            default:   nxt = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HOLD;
        else        state <= nxt;
    end

    always_comb begin
        req   = 1'b0;
        load  = 1'b0;
        busy  = 1'b0;
        start = 1'b0;
        unique case (state)
            ST_HOLD: busy = 1'b1;
            ST_FETCH: begin
                busy = 1'b1;
                req  = 1'b1;
                load = rsp_valid;
            end
            ST_LAUNCH: start = 1'b1;
            ST_RUN: ;
            default: busy = 1'b1;
        endcase
    end
endmodule

// File: rtl/rvl_vec_decode.sv
module rvl_vec_decode
    import rvl_pkg::*;
#(
    parameter int unsigned WORD_W    = 32,
    parameter int unsigned ALIGN_LSB = 4
) (
    input  logic [WORD_W-1:0] vec,
    output logic [WORD_W-1:0] pc_init,
    output logic [WORD_W-1:0] cfg_init
);
    localparam logic [WORD_W-1:0] CFG_MASK =
        (WORD_W'(1) << BIT_ORDER) | (WORD_W'(1) << BIT_RC_LO) |
        (WORD_W'(1) << BIT_RC_HI) | (WORD_W'(1) << BIT_LOCK);

    always_comb begin
        pc_init  = {vec[WORD_W-1:ALIGN_LSB], {ALIGN_LSB{1'b0}}};
        cfg_init = vec & CFG_MASK;
    end
endmodule

// File: rtl/rvl_cfg_reg.sv
module rvl_cfg_reg
    import rvl_pkg::*;
#(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned LOW_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] load_val,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] q
);
    logic locked;
    assign locked = q[BIT_LOCK];

    // Upper field: always writable after start-up
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q[WORD_W-1:LOW_W] <= '0;
        else if (load)  q[WORD_W-1:LOW_W] <= load_val[WORD_W-1:LOW_W];
        else if (wr_en) q[WORD_W-1:LOW_W] <= wr_data[WORD_W-1:LOW_W];
    end

    // Low field: frozen by the lock bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                q[LOW_W-1:0] <= '0;
        else if (load)             q[LOW_W-1:0] <= load_val[LOW_W-1:0];
        else if (wr_en && !locked) q[LOW_W-1:0] <= wr_data[LOW_W-1:0];
    end
endmodule

// File: rtl/rvec_loader.sv
module rvec_loader
    import rvl_pkg::*;
#(
    parameter int unsigned         WORD_W      = 32,
    parameter logic [WORD_W-1:0]   VEC_ADDR    = 32'hFFFF_FFE0,
    parameter logic [WORD_W-1:0]   STATUS_INIT = 32'h0000_0010,
    parameter int unsigned         ALIGN_LSB   = 4,
    parameter int unsigned         LOW_W       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              mem_req,
    output logic [WORD_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              cfg_we,
    input  logic [WORD_W-1:0] cfg_wdata,
    output logic [WORD_W-1:0] pc_out,
    output logic [WORD_W-1:0] status_out,
    output logic [WORD_W-1:0] cfg_out,
    output logic              busy,
    output logic              start
);
    boot_state_t       state;
    logic              load;
    logic [WORD_W-1:0] pc_init;
    logic [WORD_W-1:0] cfg_init;

    rvl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rsp_valid (mem_rvalid),
        .state     (state),
        .req       (mem_req),
        .load      (load),
        .busy      (busy),
        .start     (start)
    );

    rvl_vec_decode #(.WORD_W(WORD_W), .ALIGN_LSB(ALIGN_LSB)) u_dec (
        .vec      (mem_rdata),
        .pc_init  (pc_init),
        .cfg_init (cfg_init)
    );

    rvl_cfg_reg #(.WORD_W(WORD_W), .LOW_W(LOW_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (cfg_init),
        .wr_en    (cfg_we && (state inside {ST_LAUNCH, ST_RUN})),
        .wr_data  (cfg_wdata),
        .q        (cfg_out)
    );

    assign mem_addr = VEC_ADDR;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_out     <= '0;
            status_out <= '0;
        end else if (load) begin
            pc_out     <= pc_init;
            status_out <= STATUS_INIT;
        end
    end
endmodule

// File: rtl/rvl_checker.sv
module rvl_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_req,
    input logic [31:0] mem_addr,
    input logic        mem_rvalid,
    input logic [31:0] pc_out,
    input logic [31:0] status_out,
    input logic [31:0] cfg_out,
    input logic        busy,
    input logic        start
);
    assert_req_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_addr == 32'hFFFF_FFE0);

    assert_pc_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> pc_out[3:0] == 4'h0);

    assert_status_init_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> status_out == 32'h0000_0010);

    assert_cfg_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> cfg_out[31:4] == 28'h0);

    assert_start_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start);

    assert_start_after_rsp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_rvalid) |=> (start && !busy));

    assert_busy_start_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && start));

    assert_busy_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_rvalid) |=> $stable(cfg_out));

    assert_lock_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cfg_out[3]) |=> $stable(cfg_out[7:0]));

    assert_stray_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && mem_rvalid) |=> ($stable(pc_out) && $stable(status_out)));
endmodule

bind rvec_loader rvl_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .pc_out     (pc_out),
    .status_out (status_out),
    .cfg_out    (cfg_out),
    .busy       (busy),
    .start      (start)
);

// File: tb/tb_rvec_loader.sv
`timescale 1ns/1ps
module tb_rvec_loader;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] pc_out, status_out, cfg_out;
    logic        busy, start;

    always #4 clk = ~clk;

    rvec_loader dut (
        .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .pc_out(pc_out), .status_out(status_out),
        .cfg_out(cfg_out), .busy(busy), .start(start)
    );

    typedef struct {
        logic [31:0] pc;
        logic [31:0] st;
        logic [31:0] cfg;
    } exp_t;

    exp_t exp_q[$];
    int   n_run  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // Monitor: each start pulse pops one expected load result
    always @(negedge clk) begin
        if (rst_n && start) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R6 unexpected start", 32'h1, 32'h0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(pc_out == e.pc, "R3 pc", pc_out, e.pc);
                chk(status_out == e.st, "R4 status", status_out, e.st);
                chk(cfg_out == e.cfg, "R5 cfg", cfg_out, e.cfg);
                chk(busy == 1'b0, "R6 busy at start", {31'h0, busy}, 32'h0);
            end
        end
    end

    // Driver: reset, fetch wait with stray writes, response
    task automatic boot(input logic [31:0] vec, input int wait_cyc);
        exp_t e;
        rst_n = 1'b0; cfg_we = 1'b0; mem_rvalid = 1'b0;
        repeat (2) @(negedge clk);
        chk(pc_out == 0 && status_out == 0, "R1 pc/status in reset", pc_out | status_out, 32'h0);
        chk(cfg_out == 0, "R1 R10 cfg cleared in reset", cfg_out, 32'h0);
        chk(busy && !start && !mem_req, "R1 control in reset", {29'h0, busy, start, mem_req}, 32'h4);
        rst_n = 1'b1;
        e.pc  = {vec[31:4], 4'h0};
        e.st  = 32'h0000_0010;
        e.cfg = {28'h0, vec[3:0]};
        exp_q.push_back(e);
        @(negedge clk);
        for (int i = 0; i < wait_cyc; i++) begin
            chk(mem_req && mem_addr == 32'hFFFF_FFE0, "R2 request held", mem_addr, 32'hFFFF_FFE0);
            cfg_we = 1'b1; cfg_wdata = 32'hDEAD_BEEF;
            @(negedge clk);
            chk(cfg_out == 0 && busy, "R7 write while busy", cfg_out, 32'h0);
        end
        chk(mem_req && mem_addr == 32'hFFFF_FFE0, "R2 request R10 refetch", mem_addr, 32'hFFFF_FFE0);
        cfg_we = 1'b0;
        mem_rvalid = 1'b1; mem_rdata = vec;
        @(negedge clk);
        mem_rvalid = 1'b0; mem_rdata = 32'h5A5A_5A5A;
        chk(start == 1'b1, "R6 start after response", {31'h0, start}, 32'h1);
        @(negedge clk);
        chk(start == 1'b0 && !busy, "R6 single pulse", {30'h0, busy, start}, 32'h0);
    endtask

    task automatic wr(input logic [31:0] d, input logic [31:0] exp, input string req);
        cfg_we = 1'b1; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        chk(cfg_out == exp, req, cfg_out, exp);
    endtask

    initial begin
        // Locked vector: order=1, mode=00, lock=1
        boot(32'h1234_5679, 3);
        wr(32'hABCD_EF00, 32'hABCD_EF09, "R9 locked low byte, upper written");
        mem_rvalid = 1'b1; mem_rdata = 32'h7777_7777;
        @(negedge clk);
        mem_rvalid = 1'b0;
        @(negedge clk);
        chk(pc_out == 32'h1234_5670 && status_out == 32'h10, "R11 stray response", pc_out, 32'h1234_5670);
        chk(cfg_out == 32'hABCD_EF09, "R11 stray response cfg", cfg_out, 32'hABCD_EF09);

        // Second reset, unlocked vector: order=0, mode=11, lock=0
        boot(32'hFFFF_FFF6, 0);
        wr(32'h1111_11F5, 32'h1111_11F5, "R8 unlocked full write");
        wr(32'h2222_2208, 32'h2222_2208, "R8 write sets lock");
        wr(32'h3333_3377, 32'h3333_3308, "R9 newly locked low byte");

        boot(32'h0000_0000, 1);
        wr(32'h0000_00FF, 32'h0000_00FF, "R8 R10 lock cleared by reset");
        boot(32'hFFFF_FFFF, 2);

        repeat (2) @(negedge clk);
        chk(exp_q.size() == 0, "R6 every load started", exp_q.size(), 32'h0);
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++; n_fail++;
            $display("FAIL watchdog actual=%08h expected=%08h", 32'h1, 32'h0);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule